// File: doc/BRIEF.md
# Outbound Link Address Overlay

This block sits on the transmit side of a chip-to-chip memory link. It turns a local bus address, with the 4-bit privilege ID of the requesting master and its secure flag, into the 32-bit address carried to the far device. The address first loses its upper bits through a programmable mask. The privilege ID and the secure flag are then written into programmable bit positions of the upper part. The receiving side decodes those upper bits to find the segment, the privilege and the security of the request.

A single 32-bit control word selects the mask width and both insertion positions. Software writes and reads it through a plain write-enable/data port. The path from address to link address is purely combinational and uses the register's current contents. Only addresses inside the 256 MB transmit window, whose upper nibble is 0x4, are translated. Any other address raises an error flag and yields a zero link address.

Top module: `lnk_tx_addr_ovly`

## Requirements
- R1: The control word keeps the mask select in bits 3:0, the privilege position in bits 11:8 and the secure position in bits 19:16. Every other bit reads as zero. The word resets to zero, loads on the clock edge where the write enable is high, and holds its value otherwise.
- R2: For an address inside the window, link address bits 16:0 always equal the local address bits 16:0.
- R3: A mask select value v keeps the address bits below bit 17+v and clears the bits above. Value 0 keeps 17 bits, 10 keeps 27 bits, 11 keeps 28 bits and 15 keeps all 32 bits.
- R4: A privilege position p from 1 to 15 writes privilege ID bit k to link bit 16+p+k. ID bits that would land above bit 31 are dropped. Where a bit is covered, the ID replaces the masked address bit. With p = 0 no ID is written.
- R5: A secure position s from 1 to 15 writes the secure flag to link bit 16+s, replacing the masked address bit there. With s = 0 no flag is written.
- R6: Where the secure position falls inside the privilege field, the secure flag wins that bit.
- R7: An address whose bits 31:28 are not 0x4 drives the error output high and the link address to zero. Addresses 0x4000_0000 through 0x4FFF_FFFF drive the error output low.
- R8: With mask select 11 and privilege position 12, ID 5 and address 0x4567_89A0 give 0x5567_89A0.
- R9: The translation follows its inputs in the same cycle and uses the control word held before the current clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control word |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| loc_addr | input | 32 | Local bus address |
| loc_priv | input | 4 | Privilege ID of the requester |
| loc_secure | input | 1 | Secure flag of the requester |
| link_addr | output | 32 | Outgoing link address |
| win_err | output | 1 | Address outside the transmit window |

## Verification
A control word write and a translation can fall in the same cycle. The bench raises the write enable together with a new address. It expects that cycle's link address to follow the old settings and the next cycle's link address to follow the new ones. In a single word, the secure flag and the privilege field can also claim the same link bit. The bench sets the two positions to overlap, drives opposite values into them, and checks that the secure flag takes the shared bit while the remaining ID bits keep their places.

// File: rtl/lnk_ovl_pkg.sv
package lnk_ovl_pkg;
   localparam int FLD_W    = 4;
   localparam int CFG_W    = 32;
   localparam int MSEL_LSB = 0;
   localparam int PPOS_LSB = 8;
   localparam int SPOS_LSB = 16;

   typedef struct packed {
      logic [FLD_W-1:0] sec_pos;
      logic [FLD_W-1:0] priv_pos;
      logic [FLD_W-1:0] mask_sel;
   } ovl_cfg_t;

   function automatic logic [CFG_W-1:0] cfg_to_word(ovl_cfg_t c);
      logic [CFG_W-1:0] w;
      w = '0;
      w[MSEL_LSB +: FLD_W] = c.mask_sel;
      w[PPOS_LSB +: FLD_W] = c.priv_pos;
      w[SPOS_LSB +: FLD_W] = c.sec_pos;
      return w;
   endfunction

   function automatic ovl_cfg_t word_to_cfg(logic [CFG_W-1:0] w);
      ovl_cfg_t c;
      c.mask_sel = w[MSEL_LSB +: FLD_W];
      c.priv_pos = w[PPOS_LSB +: FLD_W];
      c.sec_pos  = w[SPOS_LSB +: FLD_W];
      return c;
   endfunction
endpackage

// File: rtl/lnk_ovl_cfg.sv
module lnk_ovl_cfg
   import lnk_ovl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output ovl_cfg_t         cfg,
   output logic [CFG_W-1:0] rdata
);
   ovl_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= '0;
      else if (we) cfg_q <= word_to_cfg(wdata);
   end

   assign cfg   = cfg_q;
   assign rdata = cfg_to_word(cfg_q);

   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata[MSEL_LSB +: FLD_W] == $past(wdata[MSEL_LSB +: FLD_W])) &&
             (rdata[SPOS_LSB +: FLD_W] == $past(wdata[SPOS_LSB +: FLD_W]))); // R1
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(rdata)); // R1
endmodule

// File: rtl/lnk_ovl_mask.sv
module lnk_ovl_mask #(
   parameter int ADDR_W    = 32,
   parameter int MASK_BASE = 17,
   parameter int SEL_W     = 4
) (
   input  logic [SEL_W-1:0]  sel,
   output logic [ADDR_W-1:0] mask
);
   localparam int SEL_MAX = (1 << SEL_W) - 1;

   if (MASK_BASE + SEL_MAX > ADDR_W) begin : g_bad_range
      $error("mask select range exceeds address width");
   end

   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (b < MASK_BASE) begin : g_keep
         assign mask[b] = 1'b1;
      end else begin : g_sel
         localparam int K = b - MASK_BASE;
         assign mask[b] = (int'(sel) > K);
      end
   end
endmodule

// File: rtl/lnk_ovl_field.sv
module lnk_ovl_field #(
   parameter int ADDR_W   = 32,
   parameter int FIELD_W  = 4,
   parameter int POS_BASE = 16,
   parameter int POS_W    = 4
) (
   input  logic [POS_W-1:0]   pos,
   input  logic [FIELD_W-1:0] fld,
   output logic [ADDR_W-1:0]  val,
   output logic [ADDR_W-1:0]  hit
);
   if (POS_BASE + (1 << POS_W) - 1 >= ADDR_W + 1) begin : g_bad_pos
      $error("overlay position range exceeds address width");
   end

   always_comb begin
      val = '0;
      hit = '0;
      if (pos != '0) begin
         for (int k = 0; k < FIELD_W; k++) begin
            for (int b = 0; b < ADDR_W; b++) begin
               if (POS_BASE + int'(pos) + k == b) begin
                  hit[b] = 1'b1;
                  val[b] = fld[k];
               end
            end
         end
      end
   end
endmodule

// File: rtl/lnk_tx_addr_ovly.sv
module lnk_tx_addr_ovly
   import lnk_ovl_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          PRIV_W    = 4,
   parameter int          MASK_BASE = 17,
   parameter int          POS_BASE  = 16,
   parameter int          WIN_TAG_W = 4,
   parameter logic [3:0]  WIN_TAG   = 4'h4,
   parameter bit          SEC_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [31:0]       loc_addr,
   input  logic [3:0]        loc_priv,
   input  logic              loc_secure,
   output logic [31:0]       link_addr,
   output logic              win_err
);
   if (ADDR_W != CFG_W || WIN_TAG_W > ADDR_W || PRIV_W != 4) begin : g_bad_cfg
      $error("unsupported parameter combination");
   end

   ovl_cfg_t            cfg_q;
   logic [ADDR_W-1:0]   mask, masked, p_val, p_hit, s_val, s_hit, merged;
   logic                in_win;

   lnk_ovl_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .cfg(cfg_q), .rdata(cfg_rdata)
   );

   lnk_ovl_mask #(.ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE), .SEL_W(FLD_W)) u_mask (
      .sel(cfg_q.mask_sel), .mask(mask)
   );

   lnk_ovl_field #(.ADDR_W(ADDR_W), .FIELD_W(PRIV_W), .POS_BASE(POS_BASE), .POS_W(FLD_W)) u_priv (
      .pos(cfg_q.priv_pos), .fld(loc_priv), .val(p_val), .hit(p_hit)
   );

   lnk_ovl_field #(.ADDR_W(ADDR_W), .FIELD_W(1), .POS_BASE(POS_BASE), .POS_W(FLD_W)) u_sec (
      .pos(cfg_q.sec_pos), .fld(loc_secure), .val(s_val), .hit(s_hit)
   );

   assign masked = loc_addr & mask;
   assign in_win = (loc_addr[ADDR_W-1 -: WIN_TAG_W] == WIN_TAG[WIN_TAG_W-1:0]);

   if (SEC_WINS) begin : g_sec_first
      assign merged = (masked & ~(p_hit | s_hit)) | (p_val & ~s_hit) | s_val;
   end else begin : g_priv_first
      assign merged = (masked & ~(p_hit | s_hit)) | (s_val & ~p_hit) | p_val;
   end

   assign link_addr = in_win ? merged : '0;
   assign win_err   = !in_win;

   AST_OUT_WIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_addr[31:28] != 4'h4) |-> (win_err && link_addr == '0)); // R7
   AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !win_err |-> (link_addr[16:0] == loc_addr[16:0])); // R2
   AST_HI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_err && cfg_rdata == '0) |-> (link_addr[31:17] == '0)); // R3
   AST_SEC_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_err && cfg_q.sec_pos != '0) |->
         (link_addr[POS_BASE + int'(cfg_q.sec_pos)] == loc_secure)); // R5
   AST_PRIV_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_err && cfg_q.priv_pos != '0 && cfg_q.sec_pos == '0) |->
         (link_addr[POS_BASE + int'(cfg_q.priv_pos)] == loc_priv[0])); // R4
endmodule

// File: tb/lnk_tx_addr_ovly_test.sv
module lnk_tx_addr_ovly_test;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      bit          is_cfg;
      logic [31:0] exp_val;
      logic        exp_err;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] loc_addr = '0;
   logic [3:0]  loc_priv = '0;
   logic        loc_secure = 1'b0;
   logic [31:0] link_addr;
   logic        win_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lnk_tx_addr_ovly uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .loc_addr(loc_addr), .loc_priv(loc_priv),
      .loc_secure(loc_secure), .link_addr(link_addr), .win_err(win_err)
   );

   function automatic logic [31:0] mk(int m, int p, int s);
      return {12'b0, 4'(s), 4'b0, 4'(p), 4'b0, 4'(m)};
   endfunction

   // monitor: one expected item compared per falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_checks++;
         if (it.is_cfg) begin
            if (cfg_rdata !== it.exp_val) begin
               n_fail++;
               $display("FAIL %s: cfg_rdata=%h expected %h", it.tag, cfg_rdata, it.exp_val);
            end
         end else if (link_addr !== it.exp_val || win_err !== it.exp_err) begin
            n_fail++;
            $display("FAIL %s: link_addr=%h err=%b expected %h err=%b",
                     it.tag, link_addr, win_err, it.exp_val, it.exp_err);
         end
      end
   end

   task automatic push(bit c, logic [31:0] v, logic e, string t);
      item_t it;
      it.is_cfg = c; it.exp_val = v; it.exp_err = e; it.tag = t;
      sb.push_back(it);
   endtask

   task automatic drive(string t, logic [31:0] a, logic [3:0] id, logic sec,
                        logic [31:0] ea, logic ee);
      @(posedge clk); #1;
      loc_addr = a; loc_priv = id; loc_secure = sec;
      push(1'b0, ea, ee, t);
   endtask

   task automatic cfg_write(logic [31:0] d, logic [31:0] exp_rd, string t);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      push(1'b1, exp_rd, 1'b0, t);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         report();
      end
   end

   initial begin
      #(CLK_PERIOD * 3);
      rst_n = 1'b1;
      // reset state R1, default mask R3 and R2
      @(posedge clk); #1;
      push(1'b1, 32'h0, 1'b0, "R1 reset value");
      drive("R3 R2 reset mask 17 bits", 32'h4567_89A0, 4'h5, 1'b1, 32'h0001_89A0, 1'b0);
      // R1 reserved bits read zero
      cfg_write(32'hFFFF_FFFF, 32'h000F_0F0F, "R1 reserved bits");
      // R8 worked example
      cfg_write(mk(11, 12, 0), 32'h0000_0C0B, "R1 field load");
      drive("R8 example", 32'h4567_89A0, 4'h5, 1'b0, 32'h5567_89A0, 1'b0);
      // R3 mask sweep
      cfg_write(mk(0, 0, 0), 32'h0, "R1 clear");
      drive("R3 v=0", 32'h4FFF_FFFF, 4'hF, 1'b1, 32'h0001_FFFF, 1'b0);
      cfg_write(mk(10, 0, 0), 32'h0000_000A, "R1 v=10");
      drive("R3 v=10", 32'h4FFF_FFFF, 4'hF, 1'b1, 32'h07FF_FFFF, 1'b0);
      cfg_write(mk(15, 0, 0), 32'h0000_000F, "R1 v=15");
      drive("R3 v=15", 32'h4FFF_FFFF, 4'hF, 1'b1, 32'h4FFF_FFFF, 1'b0);
      // R4 privilege placement
      cfg_write(mk(0, 15, 0), 32'h0000_0F00, "R1 p=15");
      drive("R4 p=15 top bit only", 32'h4FFF_FFFF, 4'hF, 1'b0, 32'h8001_FFFF, 1'b0);
      cfg_write(mk(0, 1, 0), 32'h0000_0100, "R1 p=1");
      drive("R4 p=1", 32'h4FFF_FFFF, 4'hA, 1'b0, 32'h0015_FFFF, 1'b0);
      cfg_write(mk(15, 12, 0), 32'h0000_0C0F, "R1 p=12 v=15");
      drive("R4 id replaces address bits", 32'h4FFF_FFFF, 4'h0, 1'b0, 32'h0FFF_FFFF, 1'b0);
      // R5 secure placement
      cfg_write(mk(0, 0, 1), 32'h0001_0000, "R1 s=1");
      drive("R5 s=1", 32'h4000_1234, 4'hF, 1'b1, 32'h0002_1234, 1'b0);
      cfg_write(mk(15, 0, 15), 32'h000F_000F, "R1 s=15");
      drive("R5 s=15 set", 32'h4FFF_FFFF, 4'h0, 1'b1, 32'hCFFF_FFFF, 1'b0);
      drive("R5 s=15 clear", 32'h4FFF_FFFF, 4'h0, 1'b0, 32'h4FFF_FFFF, 1'b0);
      // R6 collision
      cfg_write(mk(11, 12, 13), 32'h000D_0C0B, "R1 p=12 s=13");
      drive("R6 secure 1 over id 0", 32'h4567_89A0, 4'h0, 1'b1, 32'h2567_89A0, 1'b0);
      drive("R6 secure 0 over id F", 32'h4567_89A0, 4'hF, 1'b0, 32'hD567_89A0, 1'b0);
      // R7 window
      drive("R7 below window", 32'h3FFF_FFFF, 4'h5, 1'b1, 32'h0, 1'b1);
      drive("R7 above window", 32'h5000_0000, 4'h5, 1'b1, 32'h0, 1'b1);
      cfg_write(mk(11, 0, 0), 32'h0000_000B, "R1 v=11");
      drive("R7 window low edge", 32'h4000_0000, 4'h5, 1'b1, 32'h0000_0000, 1'b0);
      drive("R7 window high edge", 32'h4FFF_FFFF, 4'h5, 1'b1, 32'h0FFF_FFFF, 1'b0);
      // R9 write and translation in the same cycle
      cfg_write(mk(11, 12, 0), 32'h0000_0C0B, "R1 reload");
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_wdata = mk(0, 0, 0);
      loc_addr = 32'h4567_89A0; loc_priv = 4'h5; loc_secure = 1'b0;
      push(1'b0, 32'h5567_89A0, 1'b0, "R9 old config during write");
      @(posedge clk); #1;
      cfg_we = 1'b0;
      push(1'b0, 32'h0001_89A0, 1'b0, "R9 new config after write");
      drive("R9 input change same cycle", 32'h4000_0001, 4'h5, 1'b0, 32'h0000_0001, 1'b0);
      repeat (4) @(posedge clk);
      done = 1'b1;
      report();
   end
endmodule